// File: doc/BRIEF.md
# Asynchronous Serial Channel with Multiprocessor Addressing

This block is one full-duplex asynchronous serial channel. The host loads a character into a transmit holding register. The character moves into a shift register as soon as the line is free, which lets the next character be written while the current one is on the wire. On the receive side, a frame is assembled from the line, checked, and placed in a receive buffer, where it stays until the host reads it. Sticky flags report parity, framing and overrun errors, and a clear pulse resets them.

The character format is set by configuration pins. With parity off, the data field is 7, 8 or 9 bits long. With parity on, it is 6, 7 or 8 bits long, followed by an even or odd parity bit. In multiprocessor mode the parity bit is replaced by an address/data marker bit. The transmitter takes this bit from the host along with the character, and the receiver reports it next to the received data. A 16-bit reload counter produces the 16x oversampling tick. Rising edges of an external clock pin can replace it.

Top module: `serial_mp_port`

## Requirements
- R1: After reset, `txd` is high, `tx_empty` is 1, `tx_busy` is 0, and `rx_full`, `rx_perr`, `rx_ferr` and `rx_ovr` are 0.
- R2: With `cfg_ext_clk`=0, the oversampling tick repeats every `cfg_reload`+1 clocks, and one bit on the line lasts 16 ticks, so each transmitted bit is 16*(`cfg_reload`+1) clocks long.
- R3: With `cfg_ext_clk`=1, each rising edge of `ext_clk` is one oversampling tick and the reload counter has no effect. Without edges, the line does not advance.
- R4: A frame is a start bit (0), then the data bits LSB first, then the optional extra bit, then one stop bit (1). The data length is 6+`cfg_len` when parity is active and 7+`cfg_len` otherwise, where `cfg_len`=3 acts as 2.
- R5: Parity is active when `cfg_par_en`=1 and `cfg_mp_en`=0. The extra bit is then the XOR of the data bits, inverted when `cfg_par_odd`=1.
- R6: When `cfg_mp_en`=1, parity is off and the extra bit is present. On transmit it carries `tx_adr` as sampled with the write. On receive it appears on `rx_adr`.
- R7: A write (`tx_we`) with `tx_empty`=1 fills the holding register and drops `tx_empty`. The register moves to the shifter when the line is idle, and `tx_empty` then rises. A write while `tx_empty`=0 is ignored.
- R8: A falling edge on `rxd` starts a frame only if the majority of three samples around the middle of the start bit is low, so shorter pulses are ignored. Each later bit is a majority of three samples around its middle.
- R9: At the middle of the stop bit, a completed frame is stored in `rx_rdata`/`rx_adr` and `rx_full` rises. A `rx_re` pulse clears `rx_full`.
- R10: A received frame whose extra bit does not match the active parity sets `rx_perr`.
- R11: A received frame whose stop bit is sampled low sets `rx_ferr` and is still stored.
- R12: A frame that completes while `rx_full`=1 sets `rx_ovr` and is discarded. The buffered data is kept.
- R13: `err_clr` clears `rx_perr`, `rx_ferr` and `rx_ovr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_reload | input | 16 | Reload value of the tick counter |
| cfg_ext_clk | input | 1 | Use edges of ext_clk as tick |
| ext_clk | input | 1 | External oversampling clock |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Odd parity select |
| cfg_len | input | 2 | Data length step |
| cfg_mp_en | input | 1 | Multiprocessor mode |
| tx_we | input | 1 | Write strobe for transmit data |
| tx_wdata | input | 9 | Transmit character |
| tx_adr | input | 1 | Address marker for the written character |
| tx_empty | output | 1 | Holding register free |
| tx_busy | output | 1 | Shifter active |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_re | input | 1 | Read strobe, frees the receive buffer |
| rx_rdata | output | 9 | Received character |
| rx_adr | output | 1 | Received address marker |
| rx_full | output | 1 | Receive buffer holds unread data |
| rx_perr | output | 1 | Sticky parity error |
| rx_ferr | output | 1 | Sticky framing error |
| rx_ovr | output | 1 | Sticky overrun |
| err_clr | input | 1 | Clears the error flags |

## Verification
The embedded assertions check the properties that hold on every cycle. Ticks from the reload counter are never adjacent when the reload value is nonzero, and edge ticks are never adjacent either. An idle line is high. A load empties the holding register and starts the shifter, and a write to a full register leaves it unchanged. A read frees the buffer, an overrun flag rises only over a full unread buffer, and a framing flag appears only with stored data. The bench's scenarios cover what only whole frames can show: every data length and parity setting on both paths via loopback, bit length against the reload value, the stall without external edges, rejection of a short start pulse, and retention of the first character under overrun.

// File: rtl/smp_pkg.sv
package smp_pkg;
  localparam int OVS     = 16;
  localparam int SUB_W   = $clog2(OVS);
  localparam int DMAX    = 9;
  localparam int FRM_MAX = DMAX + 3;
  localparam int IDX_W   = $clog2(FRM_MAX + 1);

  typedef struct packed {
    logic             par_en;
    logic             par_odd;
    logic             mp_en;
    logic [IDX_W-1:0] dbits;
    logic             has_ext;
  } fmt_t;

  function automatic fmt_t make_fmt(input logic par_en, input logic odd,
                                    input logic mp, input logic [1:0] len);
    fmt_t f;
    logic [1:0] l;
    l         = (len == 2'd3) ? 2'd2 : len;
    f.par_en  = par_en & ~mp;
    f.par_odd = odd;
    f.mp_en   = mp;
    f.dbits   = (f.par_en ? IDX_W'(6) : IDX_W'(7)) + IDX_W'(l);
    f.has_ext = f.par_en | mp;
    return f;
  endfunction

  function automatic logic [DMAX-1:0] dmask(input logic [IDX_W-1:0] n);
    logic [DMAX-1:0] m;
    for (int i = 0; i < DMAX; i++) m[i] = (IDX_W'(i) < n);
    return m;
  endfunction
endpackage

// File: rtl/smp_baud.sv
module smp_baud #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] reload,
  input  logic             use_ext,
  input  logic             ext_clk,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       ext_q, ext_d;
  logic             tick_d, rise;

  always_comb begin
    ext_d  = {ext_q[1:0], ext_clk};
    rise   = ext_q[1] & ~ext_q[2];
    cnt_d  = (cnt_q == '0) ? reload : cnt_q - 1'b1;
    tick_d = use_ext ? rise : (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ext_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ext_q <= ext_d;
      tick  <= tick_d;
    end
  end

  // R2: internal ticks never back to back when the reload value is nonzero
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && !$past(use_ext) && !$past(use_ext, 2) && $past(reload, 2) != '0) |-> !tick);
  // R3: edge-derived ticks never back to back
  a_r3_ext_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && $past(use_ext) && $past(use_ext, 2)) |-> !tick);
endmodule

// File: rtl/smp_tx.sv
module smp_tx
  import smp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  fmt_t            fmt,
  input  logic            we,
  input  logic [DMAX-1:0] wdata,
  input  logic            adr,
  output logic            empty,
  output logic            busy,
  output logic            txd
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

  logic [DMAX-1:0]    hold_q, hold_d, md;
  logic               hadr_q, hadr_d, hfull_q, hfull_d;
  logic [FRM_MAX-1:0] sh_q, sh_d, fr;
  logic               busy_q, busy_d, load, par, xbit;
  logic [SUB_W-1:0]   sub_q, sub_d;
  logic [IDX_W-1:0]   left_q, left_d, nbits;

  always_comb begin
    md   = hold_q & dmask(fmt.dbits);
    par  = (^md) ^ fmt.par_odd;
    xbit = (fmt.mp_en & hadr_q) | (fmt.par_en & par);
    fr    = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < DMAX; i++)
      if (IDX_W'(i) < fmt.dbits) fr[i+1] = md[i];
    if (fmt.has_ext) fr[fmt.dbits + IDX_W'(1)] = xbit;
    nbits = fmt.dbits + IDX_W'(2) + IDX_W'(fmt.has_ext);
  end

  always_comb begin
    load    = !busy_q && hfull_q;
    hold_d  = hold_q;
    hadr_d  = hadr_q;
    hfull_d = hfull_q;
    sh_d    = sh_q;
    busy_d  = busy_q;
    sub_d   = sub_q;
    left_d  = left_q;
    if (we && !hfull_q) begin
      hold_d  = wdata;
      hadr_d  = adr;
      hfull_d = 1'b1;
    end
    if (load) begin
      hfull_d = 1'b0;
      sh_d    = fr;
      busy_d  = 1'b1;
      sub_d   = '0;
      left_d  = nbits;
    end else if (busy_q && tick) begin
      sub_d = sub_q + 1'b1;
      if (sub_q == SUB_LAST) begin
        sh_d   = {1'b1, sh_q[FRM_MAX-1:1]};
        left_d = left_q - 1'b1;
        if (left_q == IDX_W'(1)) busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      hadr_q  <= 1'b0;
      hfull_q <= 1'b0;
      sh_q    <= '1;
      busy_q  <= 1'b0;
      sub_q   <= '0;
      left_q  <= '0;
    end else begin
      hold_q  <= hold_d;
      hadr_q  <= hadr_d;
      hfull_q <= hfull_d;
      sh_q    <= sh_d;
      busy_q  <= busy_d;
      sub_q   <= sub_d;
      left_q  <= left_d;
    end
  end

  assign empty = !hfull_q;
  assign busy  = busy_q;
  assign txd   = sh_q[0];

  // R1: idle line rests at mark
  a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd);
  // R7: a write into a full holding register changes nothing
  a_r7_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hfull_q && busy_q) |=> $stable(hold_q) && $stable(hadr_q));
  // R7: a load frees the holding register and starts the shifter
  a_r7_load_frees: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy_q && !hfull_q));
endmodule

// File: rtl/smp_rx.sv
module smp_rx
  import smp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  fmt_t            fmt,
  input  logic            rxd,
  input  logic            re,
  input  logic            err_clr,
  output logic [DMAX-1:0] rdata,
  output logic            radr,
  output logic            full,
  output logic            perr,
  output logic            ferr,
  output logic            ovr
);
  localparam logic [SUB_W-1:0] MID  = SUB_W'(OVS / 2 - 1);
  localparam logic [SUB_W-1:0] LAST = SUB_W'(OVS - 1);

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA} rx_st_t;

  rx_st_t           state_q, state_d;
  logic [1:0]       sync_q, h_q, h_d;
  logic             rx_s, vote, done, stop_ok, xb, perr_now;
  logic [SUB_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] bidx_q, bidx_d, last_idx;
  logic [DMAX:0]    sh_q, sh_d;
  logic [DMAX-1:0]  md, data_q, data_d;
  logic             adr_q, adr_d, full_q, full_d;
  logic             perr_q, perr_d, ferr_q, ferr_d, ovr_q, ovr_d;

  assign rx_s     = sync_q[1];
  assign vote     = (h_q[1] & h_q[0]) | (h_q[1] & rx_s) | (h_q[0] & rx_s);
  assign last_idx = fmt.dbits + IDX_W'(fmt.has_ext);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bidx_d  = bidx_q;
    sh_d    = sh_q;
    h_d     = h_q;
    done    = 1'b0;
    stop_ok = 1'b0;
    if (tick) begin
      h_d = {h_q[0], rx_s};
      case (state_q)
        RX_IDLE: if (h_q[0] && !rx_s) begin
          state_d = RX_START;
          cnt_d   = '0;
        end
        RX_START: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == MID) begin
            if (!vote) begin
              state_d = RX_DATA;
              cnt_d   = '0;
              bidx_d  = '0;
            end else begin
              state_d = RX_IDLE;
            end
          end
        end
        RX_DATA: begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            if (bidx_q == last_idx) begin
              done    = 1'b1;
              stop_ok = vote;
              state_d = RX_IDLE;
            end else begin
              sh_d[bidx_q] = vote;
              bidx_d       = bidx_q + 1'b1;
            end
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_comb begin
    md       = sh_q[DMAX-1:0] & dmask(fmt.dbits);
    xb       = sh_q[fmt.dbits];
    perr_now = fmt.par_en & (xb ^ (^md) ^ fmt.par_odd);
    data_d   = data_q;
    adr_d    = adr_q;
    full_d   = full_q;
    perr_d   = perr_q;
    ferr_d   = ferr_q;
    ovr_d    = ovr_q;
    if (err_clr) begin
      perr_d = 1'b0;
      ferr_d = 1'b0;
      ovr_d  = 1'b0;
    end
    if (re) full_d = 1'b0;
    if (done) begin
      if (!full_q || re) begin
        data_d = md;
        adr_d  = fmt.mp_en & xb;
        full_d = 1'b1;
        perr_d = perr_d | perr_now;
        ferr_d = ferr_d | !stop_ok;
      end else begin
        ovr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      h_q     <= 2'b11;
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      adr_q   <= 1'b0;
      full_q  <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], rxd};
      h_q     <= h_d;
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bidx_q  <= bidx_d;
      sh_q    <= sh_d;
      data_q  <= data_d;
      adr_q   <= adr_d;
      full_q  <= full_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
      ovr_q   <= ovr_d;
    end
  end

  assign rdata = data_q;
  assign radr  = adr_q;
  assign full  = full_q;
  assign perr  = perr_q;
  assign ferr  = ferr_q;
  assign ovr   = ovr_q;

  // R9: a read with no frame finishing frees the buffer
  a_r9_read_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (re && !done) |=> !full_q);
  // R12: overrun only over a full, unread buffer
  a_r12_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_q) |-> ($past(full_q) && !$past(re)));
  // R11: a framing error always comes with stored data
  a_r11_ferr_stored: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ferr_q) |-> full_q);
endmodule

// File: rtl/serial_mp_port.sv
module serial_mp_port
  import smp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_reload,
  input  logic             cfg_ext_clk,
  input  logic             ext_clk,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_mp_en,
  input  logic             tx_we,
  input  logic [DMAX-1:0]  tx_wdata,
  input  logic             tx_adr,
  output logic             tx_empty,
  output logic             tx_busy,
  output logic             txd,
  input  logic             rxd,
  input  logic             rx_re,
  output logic [DMAX-1:0]  rx_rdata,
  output logic             rx_adr,
  output logic             rx_full,
  output logic             rx_perr,
  output logic             rx_ferr,
  output logic             rx_ovr,
  input  logic             err_clr
);
  logic [1:0] rst_q;
  logic       rst_int_n, tick;
  fmt_t       fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int_n = rst_q[1];

  assign fmt = make_fmt(cfg_par_en, cfg_par_odd, cfg_mp_en, cfg_len);

  smp_baud #(.CNT_W(CNT_W)) i_baud (
    .clk(clk), .rst_n(rst_int_n), .reload(cfg_reload),
    .use_ext(cfg_ext_clk), .ext_clk(ext_clk), .tick(tick)
  );

  smp_tx i_tx (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .fmt(fmt),
    .we(tx_we), .wdata(tx_wdata), .adr(tx_adr),
    .empty(tx_empty), .busy(tx_busy), .txd(txd)
  );

  smp_rx i_rx (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .fmt(fmt),
    .rxd(rxd), .re(rx_re), .err_clr(err_clr),
    .rdata(rx_rdata), .radr(rx_adr), .full(rx_full),
    .perr(rx_perr), .ferr(rx_ferr), .ovr(rx_ovr)
  );
endmodule

// File: tb/test_serial_mp_port.sv
module test_serial_mp_port;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_reload = 16'd1;
  logic        cfg_ext_clk = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_mp_en = 1'b0;
  logic [1:0]  cfg_len = 2'd0;
  logic        tx_we = 1'b0, tx_adr = 1'b0, rx_re = 1'b0, err_clr = 1'b0;
  logic [8:0]  tx_wdata = '0;
  logic        tx_empty, tx_busy, txd, rxd, rx_adr, rx_full, rx_perr, rx_ferr, rx_ovr;
  logic [8:0]  rx_rdata;
  logic        lb = 1'b0, rx_drv = 1'b1, ext_run = 1'b0;
  logic [1:0]  ext_cnt = 2'd0;
  logic        ext_clk;
  int          n_chk = 0, n_err = 0, bit_clks = 32;
  bit          done_flag = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) if (ext_run) ext_cnt <= ext_cnt + 2'd1;
  assign ext_clk = ext_cnt[1];
  assign rxd = lb ? txd : rx_drv;

  serial_mp_port i_serial_mp_port (
    .clk(clk), .rst_n(rst_n), .cfg_reload(cfg_reload), .cfg_ext_clk(cfg_ext_clk),
    .ext_clk(ext_clk), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_len(cfg_len), .cfg_mp_en(cfg_mp_en), .tx_we(tx_we), .tx_wdata(tx_wdata),
    .tx_adr(tx_adr), .tx_empty(tx_empty), .tx_busy(tx_busy), .txd(txd), .rxd(rxd),
    .rx_re(rx_re), .rx_rdata(rx_rdata), .rx_adr(rx_adr), .rx_full(rx_full),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr), .err_clr(err_clr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic int data_len(input bit pe, input bit mp, input int ln);
    return ((pe && !mp) ? 6 : 7) + ((ln == 3) ? 2 : ln);
  endfunction

  function automatic bit calc_par(input logic [8:0] d, input int n, input bit odd);
    bit p = odd;
    for (int i = 0; i < n; i++) p ^= d[i];
    return p;
  endfunction

  task automatic write_tx(input logic [8:0] d, input bit a);
    tx_wdata = d; tx_adr = a; tx_we = 1'b1;
    @(negedge clk);
    tx_we = 1'b0;
  endtask

  task automatic pulse_re;
    rx_re = 1'b1; @(negedge clk); rx_re = 1'b0;
  endtask

  task automatic pulse_clr;
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
  endtask

  task automatic decode_tx(input int nd, input bit has_ext, output logic [8:0] data,
                           output bit ext, output bit stop, output bit st);
    int to = 0;
    while (txd !== 1'b0 && to < 20000) begin @(negedge clk); to++; end
    wclk(bit_clks / 2);
    st = (txd == 1'b0);
    data = '0;
    for (int i = 0; i < nd; i++) begin wclk(bit_clks); data[i] = txd; end
    ext = 1'b0;
    if (has_ext) begin wclk(bit_clks); ext = txd; end
    wclk(bit_clks);
    stop = txd;
  endtask

  task automatic send_rx(input int nd, input logic [8:0] d, input bit has_ext,
                         input bit ext, input bit stop);
    rx_drv = 1'b0; wclk(bit_clks);
    for (int i = 0; i < nd; i++) begin rx_drv = d[i]; wclk(bit_clks); end
    if (has_ext) begin rx_drv = ext; wclk(bit_clks); end
    rx_drv = stop; wclk(bit_clks);
    rx_drv = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
    end
  end

  initial begin
    logic [8:0] d, got;
    bit ext, stop, st;
    int n;
    wclk(4);
    rst_n = 1'b1;
    wclk(4);
    // R1 reset state
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(tx_empty == 1'b1 && tx_busy == 1'b0, "R1 tx flags", {tx_empty, tx_busy}, 2);
    chk({rx_full, rx_perr, rx_ferr, rx_ovr} == 4'b0, "R1 rx flags",
        {rx_full, rx_perr, rx_ferr, rx_ovr}, 0);

    // R4 R5 R6 R9: loopback sweep over formats
    lb = 1'b1;
    for (int mp = 0; mp < 2; mp++)
      for (int pe = 0; pe < 2; pe++)
        for (int od = 0; od < 2; od++)
          for (int ln = 0; ln < 4; ln++)
            for (int k = 0; k < 4; k++) begin
              int nd;
              bit hx, a, xe;
              logic [8:0] m, ed;
              if (od == 1 && (pe == 0 || mp == 1)) continue;
              cfg_mp_en = mp[0]; cfg_par_en = pe[0]; cfg_par_odd = od[0]; cfg_len = ln[1:0];
              nd = data_len(pe[0], mp[0], ln);
              hx = (pe == 1) || (mp == 1);
              m  = 9'((1 << nd) - 1);
              case (k)
                0: d = 9'h000;
                1: d = 9'h1FF;
                2: d = 9'h0A5;
                default: d = 9'h13C;
              endcase
              a  = k[0];
              ed = d & m;
              xe = mp ? a : calc_par(d, nd, od[0]);
              write_tx(d, a);
              decode_tx(nd, hx, got, ext, stop, st);
              chk(st == 1'b0 ? 1'b0 : 1'b1, "R4 start bit", st, 1);
              chk(got == ed, "R4 tx data", got, ed);
              if (hx) chk(ext == xe, mp ? "R6 tx marker" : "R5 tx parity", ext, xe);
              chk(stop == 1'b1, "R4 stop bit", stop, 1);
              wclk(bit_clks);
              chk(rx_full == 1'b1 && rx_rdata == ed, "R9 rx data", rx_rdata, ed);
              chk(rx_adr == (mp ? a : 1'b0), "R6 rx marker", rx_adr, mp ? a : 0);
              chk(rx_perr == 1'b0, "R5 rx parity ok", rx_perr, 0);
              pulse_re();
              chk(rx_full == 1'b0, "R9 read frees", rx_full, 0);
            end
    lb = 1'b0;
    cfg_mp_en = 0; cfg_par_en = 0; cfg_par_odd = 0; cfg_len = 0;

    // R7 double buffer
    write_tx(9'h041, 0);
    wclk(2);
    chk(tx_empty == 1'b1 && tx_busy == 1'b1, "R7 moved to shifter", {tx_empty, tx_busy}, 3);
    write_tx(9'h022, 0);
    chk(tx_empty == 1'b0, "R7 holding full", tx_empty, 0);
    write_tx(9'h07F, 0);
    decode_tx(7, 0, got, ext, stop, st);
    chk(got == 9'h041, "R7 first char", got, 9'h041);
    decode_tx(7, 0, got, ext, stop, st);
    chk(got == 9'h022, "R7 second char, third ignored", got, 9'h022);
    wclk(bit_clks * 12);
    chk(txd == 1'b1 && tx_busy == 1'b0 && tx_empty == 1'b1, "R7 ignored write", tx_busy, 0);

    // R2 bit length from reload
    cfg_reload = 16'd3; bit_clks = 64;
    wclk(4);
    write_tx(9'h055, 0);
    while (txd != 1'b0) @(negedge clk);
    while (txd != 1'b1) @(negedge clk);
    n = 0;
    while (txd == 1'b1 && n < 1000) begin @(negedge clk); n++; end
    chk(n == 64, "R2 bit length", n, 64);
    wclk(64 * 10);

    // R3 external clock
    cfg_ext_clk = 1'b1; lb = 1'b1;
    wclk(4);
    write_tx(9'h03C, 0);
    wclk(300);
    chk(txd == 1'b0 && tx_busy == 1'b1, "R3 stalled without edges", txd, 0);
    ext_run = 1'b1;
    decode_tx(7, 0, got, ext, stop, st);
    chk(got == 9'h03C && stop == 1'b1, "R3 frame on ext ticks", got, 9'h03C);
    wclk(bit_clks);
    chk(rx_full == 1'b1 && rx_rdata == 9'h03C, "R3 rx on ext ticks", rx_rdata, 9'h03C);
    pulse_re();
    ext_run = 1'b0; cfg_ext_clk = 1'b0; lb = 1'b0;
    cfg_reload = 16'd1; bit_clks = 32;
    wclk(40);

    // R8 short low pulse is no start
    rx_drv = 1'b0; wclk(3); rx_drv = 1'b1;
    wclk(400);
    chk(rx_full == 1'b0, "R8 glitch rejected", rx_full, 0);
    send_rx(7, 9'h02B, 0, 0, 1);
    wclk(2);
    chk(rx_full == 1'b1 && rx_rdata == 9'h02B, "R8 frame after glitch", rx_rdata, 9'h02B);
    pulse_re();

    // R10 parity error, R13 clear
    cfg_par_en = 1'b1; cfg_len = 2'd2;
    send_rx(8, 9'h0C3, 1, 1, 1);
    wclk(2);
    chk(rx_perr == 1'b1 && rx_ferr == 1'b0, "R10 parity error", rx_perr, 1);
    chk(rx_rdata == 9'h0C3, "R10 data kept", rx_rdata, 9'h0C3);
    pulse_clr();
    chk(rx_perr == 1'b0, "R13 clear", rx_perr, 0);
    pulse_re();

    // R11 framing error
    cfg_par_en = 1'b0; cfg_len = 2'd0;
    send_rx(7, 9'h011, 0, 0, 0);
    wclk(2);
    chk(rx_ferr == 1'b1 && rx_full == 1'b1, "R11 framing flag", rx_ferr, 1);
    chk(rx_rdata == 9'h011, "R11 data stored", rx_rdata, 9'h011);
    pulse_clr();
    chk(rx_ferr == 1'b0, "R13 clear ferr", rx_ferr, 0);
    pulse_re();
    wclk(40);

    // R12 overrun keeps first
    send_rx(7, 9'h005, 0, 0, 1);
    send_rx(7, 9'h07A, 0, 0, 1);
    wclk(2);
    chk(rx_ovr == 1'b1, "R12 overrun flag", rx_ovr, 1);
    chk(rx_rdata == 9'h005 && rx_full == 1'b1, "R12 first kept", rx_rdata, 9'h005);
    pulse_re();
    chk(rx_full == 1'b0, "R9 read after overrun", rx_full, 0);
    pulse_clr();
    chk(rx_ovr == 1'b0, "R13 clear ovr", rx_ovr, 0);

    // R6 multiprocessor receive: parity off, 9 bits, marker reported
    cfg_mp_en = 1'b1; cfg_par_en = 1'b1; cfg_len = 2'd2;
    send_rx(9, 9'h1AB, 1, 1, 1);
    wclk(2);
    chk(rx_rdata == 9'h1AB && rx_adr == 1'b1, "R6 address frame", rx_rdata, 9'h1AB);
    chk(rx_perr == 1'b0, "R6 no parity check", rx_perr, 0);
    pulse_re();
    send_rx(9, 9'h0F0, 1, 0, 1);
    wclk(2);
    chk(rx_rdata == 9'h0F0 && rx_adr == 1'b0, "R6 data frame", rx_adr, 0);
    pulse_re();

    done_flag = 1;
    summary();
  end
endmodule